// File: doc/BRIEF.md
# Expectation Latch with Delayed Handoff

This block remembers that something is awaited and passes control onward once it arrives. A single-cycle pulse on the arm input raises a pending level, and that level stays high until a hit pulse arrives. The hit pulse clears the level and also enters a shift-register delay line. The hit comes back out of that line a fixed number of clock cycles later, still one cycle wide.

The delayed copy is driven on its own output. It is also forwarded to a handoff output, but only while the pending level is low. Normally the level has already fallen by the time the delayed pulse comes out, so each fulfilled expectation yields one handoff pulse DELAY cycles after the hit. A new arm that lands while a hit is still in the delay line raises the level again and suppresses the handoff. The handoff output can then chain this block into a sequence of further stages.

Top module: `expect_handoff`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `pending_o`, `hit_dly_o` and `handoff_o` are all 0 in the following cycle, and every hit still inside the delay line is discarded.
- R2: A cycle with `arm_i` high makes `pending_o` 1 in the following cycle.
- R3: In a cycle with neither `arm_i` nor `hit_i` high, `pending_o` keeps its value into the next cycle.
- R4: A cycle with `hit_i` high and `arm_i` low makes `pending_o` 0 in the following cycle.
- R5: A hit in cycle c drives `hit_dly_o` to 1 in cycle c+DELAY and only there. Hits in consecutive cycles give delayed pulses in consecutive cycles.
- R6: `handoff_o` is 1 exactly when `hit_dly_o` is 1 and `pending_o` is 0. A fulfilled expectation (arm, then hit, then no further arm) gives a one-cycle handoff pulse DELAY cycles after the hit.
- R7: A hit with no earlier arm still appears on `hit_dly_o`. It also appears on `handoff_o`, because `pending_o` is low.
- R8: An arm that lands after a hit but before the hit's delayed copy comes out keeps `handoff_o` at 0 in the cycle where `hit_dly_o` is 1.
- R9: When `arm_i` and `hit_i` are high in the same cycle, the arm wins and `pending_o` is 1 in the next cycle. The hit still enters the delay line, and its delayed copy is blocked from `handoff_o` while `pending_o` stays high.
- R10: A reset applied while a hit is still in the delay line stops that hit from ever appearing on `hit_dly_o` or `handoff_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | 1 | One-cycle pulse that raises the pending expectation |
| hit_i | input | 1 | One-cycle pulse marking that the awaited event has occurred |
| pending_o | output | 1 | Level that is high while an expectation is outstanding |
| hit_dly_o | output | 1 | Copy of `hit_i` delayed by DELAY cycles |
| handoff_o | output | 1 | Delayed hit, passed on only while `pending_o` is low |

## Verification
The bench targets four cases. The first is a re-arm that lands while a hit is still in the delay line: a design that gated the handoff with a stale level, or did not gate it at all, would emit a handoff pulse that should be suppressed. The second is arm and hit in the same cycle: if the hit won that conflict, the level would drop, and if the hit were dropped from the delay line, the delayed pulse would never appear. The third is a reset with hits in flight: a delay line that the reset left alone would release phantom pulses after reset is released. The last is back-to-back hits and the exact delay count: an off-by-one stage count, or a line that merges adjacent pulses, shows up as pulses that are late, early or stretched.

// File: rtl/expect_handoff_pkg.sv
// Package: expect_handoff_pkg
// Shared types for the expectation latch. The pending level is held as a
// two-value enum, so that waveforms and checks name the two states.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package expect_handoff_pkg;

    typedef enum logic {
        PEND_CLEAR = 1'b0,
        PEND_ARMED = 1'b1
    } pend_e;

    // Next state of the pending level; arm has priority over hit.
    function automatic pend_e pend_next(input pend_e cur, input logic arm, input logic hit);
        pend_e nxt;
        if (arm)      nxt = PEND_ARMED;
        else if (hit) nxt = PEND_CLEAR;
        else          nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/pend_latch.sv
// Module: pend_latch
// Set/clear storage for the outstanding expectation. An arm pulse sets the
// level and a hit pulse clears it. If both arrive in one cycle, arm wins.
// Assumes: arm_i and hit_i are synchronous to clk; reset is synchronous,
// active low.
module pend_latch
    import expect_handoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic hit_i,
    output logic pending_o
);

    pend_e state_q;
    pend_e state_d;

    // Compute the next pending state from the two request pulses.
    always_comb begin
        state_d = pend_next(state_q, arm_i, hit_i);
    end

    // Register the pending state; reset returns it to clear.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEND_CLEAR;
        else        state_q <= state_d;
    end

    assign pending_o = (state_q == PEND_ARMED);

endmodule

// File: rtl/pulse_delay.sv
// Module: pulse_delay
// Fixed delay line of DEPTH flip-flops. A pulse entering in cycle c leaves
// in cycle c+DEPTH with its width unchanged. Pulses in consecutive cycles
// stay separate.
// Assumes: DEPTH >= 1; reset is synchronous, active low, and clears
// every stage.
module pulse_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic pulse_o
);

    localparam int LAST = DEPTH - 1;

    generate
        if (DEPTH == 1) begin : g_single
            logic stage_q;

            // Single-stage delay: capture the input pulse once.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= pulse_i;
            end

            assign pulse_o = stage_q;
        end else begin : g_chain
            logic [LAST:0] stage_q;

            // Multi-stage delay: shift the input toward the last stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[LAST-1:0], pulse_i};
            end

            assign pulse_o = stage_q[LAST];
        end
    endgenerate

endmodule

// File: rtl/handoff_gate.sv
// Module: handoff_gate
// Passes the delayed hit onward only while no expectation is pending.
// Assumes: both inputs come from registers, so the output is glitch-free
// as seen by the next clocked stage.
module handoff_gate (
    input  logic dly_i,
    input  logic pending_i,
    output logic handoff_o
);

    // Block the delayed pulse whenever an expectation is still outstanding.
    always_comb begin
        handoff_o = dly_i & ~pending_i;
    end

endmodule

// File: rtl/expect_handoff.sv
// Module: expect_handoff (top)
// Expectation latch with delayed handoff. Records a pending expectation on
// arm, clears it on hit, replays the hit after DELAY cycles, and forwards
// that replay on handoff_o only while the expectation is low.
// Assumes: DELAY >= 1; all pulses are synchronous to clk; synchronous
// active-low reset.
module expect_handoff #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic hit_i,
    output logic pending_o,
    output logic hit_dly_o,
    output logic handoff_o
);

    logic pend_w;
    logic dly_w;

    pend_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm_i),
        .hit_i     (hit_i),
        .pending_o (pend_w)
    );

    pulse_delay #(.DEPTH(DELAY)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (hit_i),
        .pulse_o (dly_w)
    );

    handoff_gate u_gate (
        .dly_i     (dly_w),
        .pending_i (pend_w),
        .handoff_o (handoff_o)
    );

    assign pending_o = pend_w;
    assign hit_dly_o = dly_w;

endmodule

// File: rtl/expect_handoff_chk.sv
// Module: expect_handoff_chk
// Protocol checks on the expect_handoff ports, bound into every instance.
// Assumes: the same clock and synchronous active-low reset as the design.
module expect_handoff_chk (
    input logic clk,
    input logic rst_n,
    input logic arm_i,
    input logic hit_i,
    input logic pending_o,
    input logic hit_dly_o,
    input logic handoff_o
);

    // R1
    reset_flush_chk: assert property (@(posedge clk)
        !rst_n |=> (!pending_o && !hit_dly_o && !handoff_o));

    // R2
    arm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> pending_o);

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !hit_i) |=> $stable(pending_o));

    // R4
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !arm_i) |=> !pending_o);

    // R6
    handoff_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |-> !pending_o);

    // R9
    arm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && hit_i) |=> (pending_o && !handoff_o));

endmodule

bind expect_handoff expect_handoff_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .hit_i     (hit_i),
    .pending_o (pending_o),
    .hit_dly_o (hit_dly_o),
    .handoff_o (handoff_o)
);

// File: tb/expect_handoff_tb.sv
// Scoreboard bench: a driver task applies inputs at the falling edge and
// queues the outputs the requirements predict. A monitor samples 2 time
// units after each rising edge and compares.
module expect_handoff_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic hit = 1'b0;
    logic pending, hit_dly, handoff;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  p;
        logic  d;
        logic  h;
        string req;
    } exp_t;

    exp_t sb_q[$];

    logic           model_p  = 1'b0;
    logic [DLY-1:0] model_dl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    expect_handoff #(.DELAY(DLY)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .hit_i     (hit),
        .pending_o (pending),
        .hit_dly_o (hit_dly),
        .handoff_o (handoff)
    );

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input logic r, input logic a, input logic h, input string req);
        exp_t it;
        @(negedge clk);
        rst_n = r;
        arm   = a;
        hit   = h;
        if (!r) begin
            model_p  = 1'b0;
            model_dl = '0;
        end else begin
            if (a)      model_p = 1'b1;
            else if (h) model_p = 1'b0;
            model_dl = {model_dl[DLY-2:0], h};
        end
        it.p   = model_p;
        it.d   = model_dl[DLY-1];
        it.h   = model_dl[DLY-1] & ~model_p;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, req);
    endtask

    // Monitor: compare the outputs after each edge with the queued prediction.
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (pending !== it.p || hit_dly !== it.d || handoff !== it.h) begin
                failures++;
                $display("FAIL %s: pending/dly/handoff actual=%b%b%b expected=%b%b%b",
                         it.req, pending, hit_dly, handoff, it.p, it.d, it.h);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R1");
        idle(2, "R3");
        // R2 raise, R3 hold
        step(1'b1, 1'b1, 1'b0, "R2");
        idle(3, "R3");
        // R4 clear, R5 exact delay, R6 fulfilled handoff
        step(1'b1, 1'b0, 1'b1, "R4");
        idle(5, "R5_R6");
        // R7: hit with no prior arm
        step(1'b1, 1'b0, 1'b1, "R7");
        idle(5, "R7");
        // R8: re-arm while the hit is in flight blocks the handoff
        step(1'b1, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, 1'b0, "R8");
        idle(4, "R8");
        // R9: arm and hit together, arm wins
        step(1'b1, 1'b0, 1'b1, "R9");
        idle(3, "R9");
        step(1'b1, 1'b1, 1'b1, "R9");
        idle(5, "R9");
        // R10: reset discards hits in flight
        step(1'b1, 1'b0, 1'b1, "R10");
        step(1'b1, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b0, 1'b0, "R10");
        idle(5, "R10");
        // R5: back-to-back hits stay separate, with and without pending
        step(1'b1, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, "R5");
        idle(5, "R5");
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b1, "R6");
        idle(5, "R6");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule